// File: doc/BRIEF.md
# Bus Clock Ratio Divider

This block generates the clocks for one bus domain. It picks one of two source clocks, a codec source or a general source, through a glitch-free multiplexer. On the selected clock it then produces three clock-enable strobes. The main strobe sets the fast interconnect clock. The mid strobe and the peripheral strobe are slower, and each one fires only on a main strobe. Each strobe is high for one selected-clock cycle per period, so every derived edge falls on a main edge.

A 16-bit configuration word holds the source select and the divider codes. The parameter `DOMAIN` picks how the codes are read. The system variant (0) uses a cascaded main divider, a linear peripheral code, and a two-bit mid code with one reserved value. The peripheral variant (1) uses a single main divider and log2 codes for the two slower strobes. A legal word is held as pending and takes effect only at the next common wrap, which is the cycle where all three strobes fire together. A word that holds a reserved code is thrown away in full and sets a sticky error flag.

The configuration port runs on `clk_out`. Users gate their flops with the strobes.

Top module: `busclk_ratio_div`

## Requirements
- R1: Bit 15 of the applied word picks the source: 0 selects `clk_codec` and 1 selects `clk_general`. Once the switch has settled, `clk_out` has the period of the selected source.
- R2: Source switching is glitch-free. No high or low phase of `clk_out` is shorter than the shorter half period of the two sources, and the two source enables are never on together.
- R3: System variant: the main strobe fires once every (bits[7:3]+1)*(bits[2:0]+1) cycles of `clk_out`.
- R4: Peripheral variant: the main strobe fires once every bits[4:0]+1 cycles of `clk_out`.
- R5: System variant: bits[9:8] set the mid strobe to fire once every 1, 2 or 4 main strobes for codes 0, 1 and 3. Code 2 is reserved.
- R6: Peripheral variant: bits[9:8] set the mid strobe to fire once every 2^code main strobes.
- R7: System variant: bits[14:12] set the peripheral strobe to fire once every code+1 main strobes.
- R8: Peripheral variant: bits[14:12] set the peripheral strobe to fire once every 2^code main strobes. Codes 0 to 3 are legal and codes 4 to 7 are reserved.
- R9: The mid and peripheral strobes are high only in cycles where the main strobe is high.
- R10: A written word that holds a reserved code sets `cfg_err`, which stays set until reset. The whole word is discarded and the ratios do not change.
- R11: A legal write takes effect at the first common wrap (all three strobes high) after the write cycle, never at the wrap in the write cycle itself. Counting from that wrap, the first main, mid and peripheral strobes come M, M*H and M*P cycles later.
- R12: After reset, the codec source is selected, all ratios are 1 (all strobes high every cycle) and `cfg_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_codec | input | 1 | Codec source clock |
| clk_general | input | 1 | General source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe, sampled on `clk_out` |
| cfg_data | input | 16 | Configuration word |
| clk_out | output | 1 | Selected, glitch-free source clock |
| main_en | output | 1 | Main clock-enable strobe |
| mid_en | output | 1 | Mid-speed clock-enable strobe |
| per_en | output | 1 | Peripheral clock-enable strobe |
| cfg_err | output | 1 | Sticky reserved-code flag |

## Verification
Two events can land in the same cycle: a configuration write and the common wrap that would apply it. The bench provokes this by writing a new ratio while the reset ratios of 1 make every cycle a wrap. It then checks that all three strobes are still high in the cycle after the write, which shows that the old setting was kept for one more wrap. A reserved write is also placed over a running setting, and the bench judges by the flag and by measuring the ratios again at the next wrap.

// File: rtl/bcr_pkg.sv
`timescale 1ns/1ps
package bcr_pkg;
  localparam int CFG_W   = 16;
  localparam int MAIN_W  = 8;   // width of main ratio minus one
  localparam int SUB_W   = 3;   // width of mid / peripheral ratio minus one
  localparam int SEL_BIT = 15;
  localparam int PER_LSB = 12;
  localparam int MID_LSB = 8;
  localparam int D0_LSB  = 3;
  localparam int D0_W    = 5;
  localparam int D1_W    = 3;
  localparam int DM_W    = 5;

  typedef struct packed {
    logic              src_gen;
    logic [MAIN_W-1:0] main_m1;
    logic [SUB_W-1:0]  mid_m1;
    logic [SUB_W-1:0]  per_m1;
  } ratio_t;

  localparam ratio_t RATIO_RST = '0;
endpackage

// File: rtl/bcr_clk_mux.sv
`timescale 1ns/1ps
module bcr_clk_mux #(
  parameter int STAGES = 2
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic sel_b,
  output logic clk_o
);
  logic [1:0] src;
  logic [1:0] en_q;
  logic [1:0] want;

  assign src = {clk_b, clk_a};

  for (genvar i = 0; i < 2; i++) begin : g_src
    localparam logic RST_V = (i == 0);
    logic [STAGES-1:0] sync_q;
    logic [STAGES-1:0] sync_d;

    // request this source only once the other one has been released
    always_comb begin
      want[i] = ((i == 1) ? sel_b : ~sel_b) & ~en_q[1-i];
      sync_d  = {sync_q[STAGES-2:0], want[i]};
    end

    // sampled on the falling edge so the gate opens and closes while the source is low
    always_ff @(negedge src[i] or negedge rst_n) begin
      if (!rst_n) sync_q <= {STAGES{RST_V}};
      else        sync_q <= sync_d;
    end

    assign en_q[i] = sync_q[STAGES-1];
  end

  assign clk_o = (src[0] & en_q[0]) | (src[1] & en_q[1]);

  a_r2_single_source_a: assert property (@(posedge clk_a) disable iff (!rst_n)
    $onehot0(en_q));
  a_r2_single_source_b: assert property (@(posedge clk_b) disable iff (!rst_n)
    $onehot0(en_q));
endmodule

// File: rtl/bcr_decode.sv
`timescale 1ns/1ps
module bcr_decode
  import bcr_pkg::*;
#(
  parameter int DOMAIN = 0
) (
  input  logic [CFG_W-1:0] word,
  output ratio_t           dec,
  output logic             legal
);
  if (DOMAIN == 0) begin : g_sys
    localparam int PW = 2 * (MAIN_W + 1);
    logic [PW-1:0] fa, fb, prod;
    logic [1:0]    mid_code;
    logic          spare_unused;

    always_comb begin
      fa       = PW'(word[D0_LSB +: D0_W]) + PW'(1);
      fb       = PW'(word[0 +: D1_W]) + PW'(1);
      prod     = fa * fb;
      mid_code = word[MID_LSB +: 2];
      dec.src_gen = word[SEL_BIT];
      dec.main_m1 = MAIN_W'(prod - PW'(1));
      dec.mid_m1  = SUB_W'(mid_code);          // codes 0,1,3 map to ratio 1,2,4
      dec.per_m1  = word[PER_LSB +: SUB_W];
      legal       = (mid_code != 2'd2);
    end
    assign spare_unused = ^word[11:10];
  end else begin : g_peri
    logic [SUB_W:0] mid_r, per_r;
    logic           spare_unused;

    always_comb begin
      mid_r = (SUB_W+1)'(1) << word[MID_LSB +: 2];
      per_r = (SUB_W+1)'(1) << word[PER_LSB +: 2];
      dec.src_gen = word[SEL_BIT];
      dec.main_m1 = MAIN_W'(word[0 +: DM_W]);
      dec.mid_m1  = SUB_W'(mid_r - (SUB_W+1)'(1));
      dec.per_m1  = SUB_W'(per_r - (SUB_W+1)'(1));
      legal       = ~word[PER_LSB + 2];
    end
    assign spare_unused = ^word[11:5];
  end
endmodule

// File: rtl/bcr_cfg.sv
`timescale 1ns/1ps
module bcr_cfg
  import bcr_pkg::*;
#(
  parameter int DOMAIN = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             wrap_all,
  output ratio_t           act,
  output logic             cfg_err
);
  ratio_t dec;
  logic   legal;
  ratio_t act_q, act_d, pend_q, pend_d;
  logic   pend_v_q, pend_v_d, err_q, err_d;

  bcr_decode #(.DOMAIN(DOMAIN)) u_dec (
    .word  (cfg_data),
    .dec   (dec),
    .legal (legal)
  );

  always_comb begin
    act_d    = act_q;
    pend_d   = pend_q;
    pend_v_d = pend_v_q;
    err_d    = err_q;
    if (wrap_all && pend_v_q) begin
      act_d    = pend_q;
      pend_v_d = 1'b0;
    end
    if (cfg_wr) begin
      if (legal) begin
        pend_d   = dec;
        pend_v_d = 1'b1;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= RATIO_RST;
      pend_q   <= RATIO_RST;
      pend_v_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      act_q    <= act_d;
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
      err_q    <= err_d;
    end
  end

  assign act     = act_q;
  assign cfg_err = err_q;

  a_r10_flag_on_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !legal) |=> cfg_err);
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  a_r10_reject_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !legal && !(wrap_all && pend_v_q)) |=> ($stable(pend_q) && $stable(pend_v_q)));
  a_r11_apply_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(wrap_all));
endmodule

// File: rtl/bcr_ratio_cnt.sv
`timescale 1ns/1ps
module bcr_ratio_cnt
  import bcr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_t act,
  output logic   main_en,
  output logic   mid_en,
  output logic   per_en,
  output logic   wrap_all
);
  logic [MAIN_W-1:0] mcnt_q, mcnt_d;
  logic [SUB_W-1:0]  hcnt_q, hcnt_d, pcnt_q, pcnt_d;
  logic              main_w, mid_w, per_w;

  always_comb begin
    main_w   = (mcnt_q == act.main_m1);
    mid_w    = (hcnt_q == act.mid_m1);
    per_w    = (pcnt_q == act.per_m1);
    main_en  = main_w;
    mid_en   = main_w & mid_w;
    per_en   = main_w & per_w;
    wrap_all = main_w & mid_w & per_w;
    mcnt_d   = mcnt_q + MAIN_W'(1);
    hcnt_d   = hcnt_q;
    pcnt_d   = pcnt_q;
    if (main_w) begin
      mcnt_d = '0;
      hcnt_d = mid_w ? '0 : hcnt_q + SUB_W'(1);
      pcnt_d = per_w ? '0 : pcnt_q + SUB_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt_q <= '0;
      hcnt_q <= '0;
      pcnt_q <= '0;
    end else begin
      mcnt_q <= mcnt_d;
      hcnt_q <= hcnt_d;
      pcnt_q <= pcnt_d;
    end
  end

  // counters stay inside the applied ratios only if new ratios land on a restart
  a_r11_main_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mcnt_q <= act.main_m1);
  a_r11_mid_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt_q <= act.mid_m1);
  a_r11_per_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= act.per_m1);
endmodule

// File: rtl/busclk_ratio_div.sv
`timescale 1ns/1ps
module busclk_ratio_div
  import bcr_pkg::*;
#(
  parameter int DOMAIN      = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_codec,
  input  logic             clk_general,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  output logic             clk_out,
  output logic             main_en,
  output logic             mid_en,
  output logic             per_en,
  output logic             cfg_err
);
  ratio_t     act;
  logic       wrap_all;
  logic [1:0] rs_q;
  logic       dom_rst_n;

  bcr_clk_mux #(.STAGES(SYNC_STAGES)) u_mux (
    .clk_a (clk_codec),
    .clk_b (clk_general),
    .rst_n (rst_n),
    .sel_b (act.src_gen),
    .clk_o (clk_out)
  );

  // reset asserts at once, releases on the output clock
  always_ff @(posedge clk_out or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign dom_rst_n = rs_q[1];

  bcr_cfg #(.DOMAIN(DOMAIN)) u_cfg (
    .clk      (clk_out),
    .rst_n    (dom_rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_data (cfg_data),
    .wrap_all (wrap_all),
    .act      (act),
    .cfg_err  (cfg_err)
  );

  bcr_ratio_cnt u_cnt (
    .clk      (clk_out),
    .rst_n    (dom_rst_n),
    .act      (act),
    .main_en  (main_en),
    .mid_en   (mid_en),
    .per_en   (per_en),
    .wrap_all (wrap_all)
  );
endmodule

// File: tb/busclk_ratio_div_test.sv
`timescale 1ns/1ps
module busclk_ratio_div_test;
  localparam real CLK_PERIOD = 10.0;   // codec source
  localparam real GEN_PERIOD = 6.0;    // general source
  localparam real MIN_HALF   = 2.99;

  logic clk_codec = 1'b0;
  logic clk_general = 1'b0;
  logic rst_n = 1'b0;
  logic cw = 1'b0;
  logic [15:0] cd = '0;
  int   k_sel = 0;
  logic co0, co1, me0, me1, he0, he1, pe0, pe1, er0, er1;
  int   n_chk = 0, n_fail = 0;
  int   runt0 = 0, runt1 = 0;
  real  t_last0 = 0.0, t_last1 = 0.0;
  bit   done = 1'b0;

  wire cw0  = cw & (k_sel == 0);
  wire cw1  = cw & (k_sel == 1);
  wire tclk = (k_sel != 0) ? co1 : co0;
  wire me   = (k_sel != 0) ? me1 : me0;
  wire he   = (k_sel != 0) ? he1 : he0;
  wire pe   = (k_sel != 0) ? pe1 : pe0;
  wire er   = (k_sel != 0) ? er1 : er0;

  always #(CLK_PERIOD/2) clk_codec   = ~clk_codec;
  always #(GEN_PERIOD/2) clk_general = ~clk_general;

  busclk_ratio_div #(.DOMAIN(0)) uut (
    .clk_codec (clk_codec), .clk_general (clk_general), .rst_n (rst_n),
    .cfg_wr (cw0), .cfg_data (cd), .clk_out (co0),
    .main_en (me0), .mid_en (he0), .per_en (pe0), .cfg_err (er0));

  busclk_ratio_div #(.DOMAIN(1)) uut_p (
    .clk_codec (clk_codec), .clk_general (clk_general), .rst_n (rst_n),
    .cfg_wr (cw1), .cfg_data (cd), .clk_out (co1),
    .main_en (me1), .mid_en (he1), .per_en (pe1), .cfg_err (er1));

  // R2: phase-width monitors on both output clocks
  always @(co0) begin
    if (rst_n && ($realtime - t_last0) < MIN_HALF) runt0++;
    t_last0 = $realtime;
  end
  always @(co1) begin
    if (rst_n && ($realtime - t_last1) < MIN_HALF) runt1++;
    t_last1 = $realtime;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] fsys(bit s, int per, int mid, int d0, int d1);
    return {s, 3'(per), 2'b00, 2'(mid), 5'(d0), 3'(d1)};
  endfunction

  function automatic logic [15:0] fperi(bit s, int per, int mid, int m);
    return {s, 3'(per), 2'b00, 2'(mid), 3'b000, 5'(m)};
  endfunction

  task automatic wr(input logic [15:0] d);
    @(negedge tclk); cd = d; cw = 1'b1;
    @(negedge tclk); cw = 1'b0;
  endtask

  task automatic wait_wrap();
    int n = 0;
    do begin @(negedge tclk); n++; end while (!(me && he && pe) && n < 20000);
  endtask

  // measure first strobes after a common wrap
  task automatic ratios(input int m, input int h, input int p,
                        input string rm, input string rh, input string rp);
    int n = 0, fm = 0, fh = 0, fp = 0, mis = 0;
    wait_wrap();
    while ((fh == 0 || fp == 0) && n < 20000) begin
      @(negedge tclk); n++;
      if (me && fm == 0) fm = n;
      if (he && fh == 0) fh = n;
      if (pe && fp == 0) fp = n;
      if ((he || pe) && !me) mis++;
    end
    chk(fm == m, rm, fm, m);
    chk(fh == m*h, rh, fh, m*h);
    chk(fp == m*p, rp, fp, m*p);
    chk(mis == 0, "R9 slow strobe outside main strobe", mis, 0);
  endtask

  task automatic period_chk(input real exp, input string rq);
    real t0, dt;
    repeat (30) @(negedge tclk);
    @(posedge tclk); t0 = $realtime;
    @(posedge tclk); dt = $realtime - t0;
    chk(dt > exp - 0.01 && dt < exp + 0.01, rq, int'(dt*1000.0), int'(exp*1000.0));
  endtask

  initial begin
    #(CLK_PERIOD * 150000.0);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R11 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_codec);
    #1 rst_n = 1'b1;

    // ---------------- system variant ----------------
    k_sel = 0;
    repeat (6) @(negedge tclk);
    chk(me == 1'b1, "R12 reset main strobe", int'(me), 1);
    chk(he == 1'b1, "R12 reset mid strobe", int'(he), 1);
    chk(pe == 1'b1, "R12 reset peripheral strobe", int'(pe), 1);
    chk(er == 1'b0, "R12 reset error flag", int'(er), 0);
    period_chk(CLK_PERIOD, "R1 codec period after reset");

    // write lands on a wrap cycle: old ratios must survive that wrap
    wr(fsys(0, 0, 0, 2, 0));
    chk((me && he && pe) == 1'b1, "R11 write deferred past same-cycle wrap",
        int'(me && he && pe), 1);
    ratios(3, 1, 1, "R11 first main after apply", "R11 first mid", "R11 first per");

    for (int d0 = 0; d0 < 32; d0++) begin
      wr(fsys(0, 0, 0, d0, 0));
      ratios(d0 + 1, 1, 1, "R3 main ratio bits 7:3", "R3 mid", "R3 per");
    end
    for (int d1 = 0; d1 < 8; d1++) begin
      wr(fsys(0, 0, 0, 1, d1));
      ratios(2 * (d1 + 1), 1, 1, "R3 main ratio cascade", "R3 mid", "R3 per");
    end
    for (int mi = 0; mi < 3; mi++) begin
      for (int pc = 0; pc < 8; pc++) begin
        int code = (mi == 2) ? 3 : mi;
        int hr   = (mi == 0) ? 1 : (mi == 1) ? 2 : 4;
        wr(fsys(0, pc, code, 1, 0));
        ratios(2, hr, pc + 1, "R3 main", "R5 mid code", "R7 peripheral code");
      end
    end
    wr(fsys(0, 6, 3, 31, 7));
    ratios(256, 4, 7, "R3 largest main", "R5 mid at largest", "R7 per at largest");

    wr(fsys(0, 2, 1, 4, 0));
    ratios(5, 2, 3, "R3 main before reserved", "R5 mid before reserved", "R7 per before reserved");
    wr(fsys(0, 5, 2, 9, 1));
    chk(er == 1'b1, "R10 reserved mid code flags error", int'(er), 1);
    ratios(5, 2, 3, "R10 main kept", "R10 mid kept", "R10 per kept");
    repeat (5) @(negedge tclk);
    chk(er == 1'b1, "R10 flag sticky", int'(er), 1);

    wr(fsys(1, 0, 0, 0, 0));
    period_chk(GEN_PERIOD, "R1 general source period");
    wr(fsys(1, 1, 1, 2, 0));
    ratios(3, 2, 2, "R1 main on general source", "R5 mid on general", "R7 per on general");
    wr(fsys(0, 0, 0, 0, 0));
    period_chk(CLK_PERIOD, "R1 back to codec period");

    // ---------------- peripheral variant ----------------
    k_sel = 1;
    repeat (4) @(negedge tclk);
    chk((me && he && pe) == 1'b1, "R12 peripheral variant reset strobes", int'(me && he && pe), 1);
    chk(er == 1'b0, "R12 peripheral variant error flag", int'(er), 0);
    for (int m = 0; m < 32; m++) begin
      wr(fperi(0, 0, 0, m));
      ratios(m + 1, 1, 1, "R4 main ratio bits 4:0", "R4 mid", "R4 per");
    end
    for (int mi = 0; mi < 4; mi++) begin
      for (int pc = 0; pc < 4; pc++) begin
        wr(fperi(0, pc, mi, 1));
        ratios(2, 1 << mi, 1 << pc, "R4 main", "R6 mid log2 code", "R8 peripheral log2 code");
      end
    end
    wr(fperi(0, 1, 2, 2));
    ratios(3, 4, 2, "R4 main before reserved", "R6 mid before reserved", "R8 per before reserved");
    for (int pc = 4; pc < 8; pc++) begin
      wr(fperi(0, pc, 0, 0));
      chk(er == 1'b1, "R8 reserved peripheral code flags error", int'(er), 1);
      ratios(3, 4, 2, "R10 main kept", "R10 mid kept", "R10 per kept");
    end
    wr(fperi(1, 0, 0, 0));
    period_chk(GEN_PERIOD, "R1 peripheral variant general period");
    wr(fperi(0, 0, 0, 0));
    period_chk(CLK_PERIOD, "R1 peripheral variant codec period");

    chk(runt0 == 0, "R2 runt phases system variant", runt0, 0);
    chk(runt1 == 0, "R2 runt phases peripheral variant", runt1, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule